// File: doc/BRIEF.md
# Debug Bus Register Target

This block sits at the far end of a debug bus. A bridge master raises a request together with an address, a write flag and write data. The target performs one access and answers through a four-phase request/acknowledge handshake. Acknowledge rises once for each request and stays high for as long as the master keeps the request asserted. On reads, the returned data is held constant for the whole acknowledge period, so the master may sample it in any cycle while acknowledge is high.

The target holds a fixed identification word at address 0, which can be read but not written. Addresses 1 to `NUM_REGS` hold general-purpose scratch registers that can be both read and written. Every other address reads as zero and ignores writes.

The access is taken only on the transition from idle to requested. A request that stays high indefinitely, for example because the bridge's clock has stopped, does not repeat the access and does not lock up the target.

Top module: `dbg_reg_target`

## Requirements
- R1: A synchronous reset drives `ack` and `rd_data` to zero and clears every scratch register to zero.
- R2: When `req` is sampled high while the target is idle (`ack` low), `ack` is high after the next rising clock edge.
- R3: `ack` stays high while `req` stays high, and goes low after the first clock edge at which `req` is sampled low.
- R4: `rd_data` does not change during any cycle in which `ack` stays high.
- R5: A read of address 0 returns the parameter `ID_VALUE`. A write to address 0 is discarded.
- R6: A write to address a, where 1 <= a <= `NUM_REGS`, stores `wdata`. A later read of address a returns that value.
- R7: A read of any address above `NUM_REGS` returns zero. A write to such an address changes no register, but it is still acknowledged.
- R8: `addr`, `wr` and `wdata` are captured only in the cycle where the request is accepted. Changes to these inputs while `req` stays high have no effect, and the access is never repeated.
- R9: During the acknowledge of a write, `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Access request from the bus master |
| wr | input | 1 | 1 = write access, 0 = read access |
| addr | input | ADDR_W | Register address, valid while req is high |
| wdata | input | DATA_W | Write data, valid while req is high |
| ack | output | 1 | Acknowledge, held high until req falls |
| rd_data | output | DATA_W | Read data, held constant while ack is high |

## Verification
The assertions check the handshake rules on every cycle:
- acknowledge rises only after a request;
- acknowledge stays high while the request is held;
- acknowledge drops once the request falls;
- read data stays stable while acknowledge is high;
- the identification word is returned on reads of address 0;
- zero is returned on write acknowledges.

The register contents can only be shown by the bench's scenarios:
- a write to every one of the 256 addresses, followed by a read-back of every address;
- a held write whose data input is changed mid-request;
- a long stalled read;
- a reset in the middle of operation.

// File: rtl/dbg_tgt_pkg.sv
package dbg_tgt_pkg;

   // Handshake state: idle waiting for a request, or holding acknowledge
   typedef enum logic {
      HS_IDLE = 1'b0,
      HS_HELD = 1'b1
   } hs_state_e;

endpackage

// File: rtl/dbg_tgt_handshake.sv
module dbg_tgt_handshake
   import dbg_tgt_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic req,
   output logic fire,
   output logic ack
);

   hs_state_e state_q;

   // An access is launched only when leaving the idle state
   assign fire = (state_q == HS_IDLE) && req;
   assign ack  = (state_q == HS_HELD);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= HS_IDLE;
      end else begin
         case (state_q)
            HS_IDLE: if (req)  state_q <= HS_HELD;
            HS_HELD: if (!req) state_q <= HS_IDLE;
            default:           state_q <= HS_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/dbg_tgt_regbank.sv
module dbg_tgt_regbank #(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 64,
   parameter int NUM_REGS = 4,
   parameter logic [DATA_W-1:0] ID_VALUE = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              fire,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_value
);

   logic [NUM_REGS-1:0]             hit;
   logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
   logic                            id_hit;

   assign id_hit = (addr == '0);

   // One full-width comparator per scratch register, at address g+1
   for (genvar g = 0; g < NUM_REGS; g++) begin : g_dec
      assign hit[g] = (addr == ADDR_W'(g + 1));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         regs_q <= '0;
      end else if (fire && wr) begin
         for (int i = 0; i < NUM_REGS; i++) begin
            if (hit[i]) regs_q[i] <= wdata;
         end
      end
   end

   always_comb begin
      rd_value = '0;
      if (id_hit) rd_value = ID_VALUE;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (hit[i]) rd_value = regs_q[i];
      end
   end

endmodule

// File: rtl/dbg_tgt_rdhold.sv
module dbg_tgt_rdhold #(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              fire,
   input  logic              wr,
   input  logic [DATA_W-1:0] rd_value,
   output logic [DATA_W-1:0] rd_data
);

   // Loaded only when an access is accepted, so it holds through ack
   always_ff @(posedge clk) begin
      if (rst)       rd_data <= '0;
      else if (fire) rd_data <= wr ? '0 : rd_value;
   end

endmodule

// File: rtl/dbg_reg_target.sv
module dbg_reg_target #(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 64,
   parameter int NUM_REGS = 4,
   parameter logic [DATA_W-1:0] ID_VALUE = 64'h5A17_0C0D_E000_0001
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              ack,
   output logic [DATA_W-1:0] rd_data
);

   localparam int ADDR_SPAN = 1 << ADDR_W;

   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr_w
      $error("dbg_reg_target: ADDR_W must be 1..16");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("dbg_reg_target: DATA_W must be positive");
   end
   if (NUM_REGS < 1 || NUM_REGS >= ADDR_SPAN) begin : g_bad_regs
      $error("dbg_reg_target: NUM_REGS must fit below the address span");
   end

   logic              fire;
   logic [DATA_W-1:0] rd_value;

   dbg_tgt_handshake u_hs (
      .clk  (clk),
      .rst  (rst),
      .req  (req),
      .fire (fire),
      .ack  (ack)
   );

   dbg_tgt_regbank #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .NUM_REGS (NUM_REGS),
      .ID_VALUE (ID_VALUE)
   ) u_bank (
      .clk      (clk),
      .rst      (rst),
      .fire     (fire),
      .wr       (wr),
      .addr     (addr),
      .wdata    (wdata),
      .rd_value (rd_value)
   );

   dbg_tgt_rdhold #(
      .DATA_W (DATA_W)
   ) u_hold (
      .clk      (clk),
      .rst      (rst),
      .fire     (fire),
      .wr       (wr),
      .rd_value (rd_value),
      .rd_data  (rd_data)
   );

endmodule

// File: rtl/dbg_reg_target_chk.sv
module dbg_reg_target_chk #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 64,
   parameter logic [DATA_W-1:0] ID_VALUE = '0
) (
   input logic              clk,
   input logic              rst,
   input logic              req,
   input logic              wr,
   input logic [ADDR_W-1:0] addr,
   input logic              ack,
   input logic [DATA_W-1:0] rd_data
);

   a_r2_ack_after_req: assert property (@(posedge clk) disable iff (rst)
      (req && !ack && !$past(req)) |=> ack);

   a_r2_no_spurious_ack: assert property (@(posedge clk) disable iff (rst)
      $rose(ack) |-> $past(req));

   a_r3_ack_holds: assert property (@(posedge clk) disable iff (rst)
      (ack && req) |=> ack);

   a_r3_ack_drops: assert property (@(posedge clk) disable iff (rst)
      !req |=> !ack);

   a_r4_rdata_stable: assert property (@(posedge clk) disable iff (rst)
      ack |=> (!ack || $stable(rd_data)));

   a_r5_id_read: assert property (@(posedge clk) disable iff (rst)
      ($rose(ack) && $past(!wr && addr == '0)) |-> (rd_data == ID_VALUE));

   a_r9_write_zero: assert property (@(posedge clk) disable iff (rst)
      ($rose(ack) && $past(wr)) |-> (rd_data == '0));

endmodule

bind dbg_reg_target dbg_reg_target_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .ID_VALUE (ID_VALUE)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .req     (req),
   .wr      (wr),
   .addr    (addr),
   .ack     (ack),
   .rd_data (rd_data)
);

// File: tb/dbg_reg_target_bench.sv
module dbg_reg_target_bench;

   localparam int          AW    = 8;
   localparam int          DW    = 64;
   localparam int          NREG  = 4;
   localparam logic [63:0] ID_EXP = 64'hC0DE_F00D_1234_5678;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          req = 1'b0;
   logic          wr  = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic          ack;
   logic [DW-1:0] rd_data;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   dbg_reg_target #(
      .ADDR_W   (AW),
      .DATA_W   (DW),
      .NUM_REGS (NREG),
      .ID_VALUE (ID_EXP)
   ) u_dbg_reg_target (
      .clk     (clk),
      .rst     (rst),
      .req     (req),
      .wr      (wr),
      .addr    (addr),
      .wdata   (wdata),
      .ack     (ack),
      .rd_data (rd_data)
   );

   function automatic logic [63:0] pat(input int a);
      return 64'h9E37_79B9_7F4A_7C15 * 64'(a + 1);
   endfunction

   function automatic bit mapped(input int a);
      return (a >= 1) && (a <= NREG);
   endfunction

   task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic report;
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   // One complete handshake; hold = extra cycles req stays high
   task automatic access(input bit w, input int a, input logic [63:0] d,
                         input int hold, input bit wiggle,
                         output logic [63:0] rd);
      @(negedge clk);
      chk(ack == 1'b0, "R3 idle before request", 64'(ack), 64'd0);
      req = 1'b1; wr = w; addr = AW'(a); wdata = d;
      @(negedge clk);
      chk(ack == 1'b1, "R2 ack one cycle after request", 64'(ack), 64'd1);
      rd = rd_data;
      if (w) chk(rd_data == '0, "R9 write ack data", rd_data, 64'd0);
      for (int i = 0; i < hold; i++) begin
         if (wiggle) begin
            wdata = ~wdata; addr = addr + 8'd1; wr = ~wr;
         end
         @(negedge clk);
         chk(ack == 1'b1, "R3 ack held with req", 64'(ack), 64'd1);
         chk(rd_data == rd, "R4 data stable during ack", rd_data, rd);
      end
      req = 1'b0;
      @(negedge clk);
      chk(ack == 1'b0, "R3 ack drops after req", 64'(ack), 64'd0);
   endtask

   function automatic logic [63:0] expect_rd(input int a);
      if (a == 0) return ID_EXP;
      if (mapped(a)) return pat(a);
      return 64'd0;
   endfunction

   initial begin
      logic [63:0] r;
      repeat (3) @(negedge clk);
      chk(ack == 1'b0, "R1 ack in reset", 64'(ack), 64'd0);
      chk(rd_data == '0, "R1 rd_data in reset", rd_data, 64'd0);
      rst = 1'b0;

      // R1: scratch registers start at zero
      for (int a = 1; a <= NREG; a++) begin
         access(1'b0, a, '0, 0, 1'b0, r);
         chk(r == '0, "R1 scratch cleared", r, 64'd0);
      end

      // R5 R6 R7: write every address, ascending, varied hold
      for (int a = 0; a < 256; a++) begin
         access(1'b1, a, pat(a) ^ (a == 0 ? 64'hFFFF : 64'h0), a % 4, 1'b0, r);
      end
      // Read back every address
      for (int a = 0; a < 256; a++) begin
         access(1'b0, a, '0, (a + 1) % 3, 1'b0, r);
         if (a == 0)          chk(r == ID_EXP, "R5 id read, write discarded", r, ID_EXP);
         else if (mapped(a))  chk(r == pat(a), "R6 scratch read-back", r, pat(a));
         else                 chk(r == '0, "R7 unmapped reads zero", r, 64'd0);
      end

      // R8: held write whose inputs change mid-request
      access(1'b1, 2, 64'h1111_2222_3333_4444, 20, 1'b1, r);
      access(1'b0, 2, '0, 0, 1'b0, r);
      chk(r == 64'h1111_2222_3333_4444, "R8 captured once at accept", r,
          64'h1111_2222_3333_4444);
      access(1'b0, 3, '0, 0, 1'b0, r);
      chk(r == pat(3), "R8 neighbour untouched", r, pat(3));

      // R8 R4: stalled read held for a long time
      access(1'b0, 1, '0, 60, 1'b1, r);
      chk(r == pat(1), "R8 stalled read value", r, pat(1));

      // R1: reset during operation clears scratch registers
      @(negedge clk); rst = 1'b1;
      @(negedge clk);
      chk(ack == 1'b0, "R1 ack after reset", 64'(ack), 64'd0);
      chk(rd_data == '0, "R1 rd_data after reset", rd_data, 64'd0);
      rst = 1'b0;
      for (int a = 0; a <= NREG + 1; a++) begin
         access(1'b0, a, '0, 1, 1'b0, r);
         chk(r == (a == 0 ? ID_EXP : 64'd0), "R1 contents after reset", r,
             (a == 0 ? ID_EXP : 64'd0));
      end

      report();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      report();
      $finish;
   end

endmodule